// File: doc/BRIEF.md
# Sub-Page Access and Dirty Tracker

This unit sits beside a translation cache that holds large pages whose size is any power of two times the 4 KB base page. For every cached page it keeps a fixed sixteen-chunk record of which parts have been read and which have been written. Each chunk spans one sixteenth of its page, so the same small record serves an 64 KB page and a 1 MB page alike. Pages below sixteen base pages use one chunk per base page, and the chunks past the page's end stay unused.

A load or store reaches the tracker after translation has already picked a cache entry. The tracker picks the chunk from the page offset and tests its bit. When a load finds the accessed bit clear, or a store finds the dirty bit clear, the tracker sets the bit and queues one request asking the memory side to mark that chunk. Bits are sticky, so later touches of the same chunk queue nothing. The tracker has no stall path back to the access. When its request queue is full, it leaves the bit clear and drops the request, and a later access to that chunk asks again. A per-page enable selects chunk tracking. With the enable off, one accessed bit and one dirty bit cover the whole page.

A fill loads a new page into an entry and clears its record. Records are never loaded from memory, so a fresh entry may ask again for a chunk that memory already marks. That repeat is harmless.

Top module: `subpage_ad_tracker`

## Requirements
- R1: After reset, no request is pending (`upd_valid` low) and every entry is empty. An access to an empty entry queues nothing.
- R2: A fill stores the page size code `fill_size`, the tracking enable and the tag, and clears every accessed and dirty bit of that entry. The page size code is log2 of the page size in base pages, from 0 to 8.
- R3: A load to a tracked chunk whose accessed bit is clear queues exactly one request with `upd_dirty`=0, `upd_page_level`=0, the entry's tag and the chunk number, and then sets that bit. Further loads to that chunk queue nothing.
- R4: A store to a tracked chunk whose dirty bit is clear queues exactly one request with `upd_dirty`=1 and sets both the dirty and the accessed bit of that chunk. Later loads or stores to that chunk queue nothing.
- R5: For size code k of 4 or more, the chunk number is offset bits [11+k : 8+k], for example bits [19:16] for k=8 and bits [15:12] for k=4.
- R6: For size code k below 4, the chunk number is offset bits [11+k : 12], zero-extended. Size code 0 always gives chunk 0.
- R7: With tracking off, one page-level accessed bit and one page-level dirty bit are used under the same rules as R3 and R4. Such a request carries `upd_page_level`=1 and `upd_chunk`=0.
- R8: An access to an entry that is being filled in the same cycle is ignored and queues nothing.
- R9: When the request queue holds FIFO_DEPTH entries, a new request is dropped and its bit stays clear, so a later access to the same chunk queues the request once space exists.
- R10: Requests leave in the order they were made. While `upd_ready` is low, `upd_valid` and the request fields hold steady.
- R11: Accesses are taken every cycle with no stall. A request made when the queue is empty shows on `upd_valid` in the cycle after the clock edge that took the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Load a new page into entry `fill_idx` |
| fill_idx | input | 3 | Entry being filled |
| fill_size | input | 4 | log2 of the page size in base pages |
| fill_track | input | 1 | 1 = chunk tracking, 0 = page-level bits only |
| fill_tag | input | 28 | Identifier returned with each request for this page |
| acc_valid | input | 1 | A translated access is present |
| acc_idx | input | 3 | Entry that the access hit |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_offset | input | 20 | Byte offset within the page |
| upd_valid | output | 1 | A request is pending |
| upd_ready | input | 1 | Consumer takes the pending request |
| upd_tag | output | 28 | Tag of the page to mark |
| upd_chunk | output | 4 | Chunk to mark (0 for page-level) |
| upd_dirty | output | 1 | 1 = mark dirty and accessed, 0 = mark accessed |
| upd_page_level | output | 1 | Request covers the whole page |

## Verification
The bench chooses offsets whose bits above and below the chunk field differ. A design that took the chunk field from the wrong position for a given size would then report the wrong chunk, or would stay silent on a chunk it had never seen. Repeated loads and stores to one chunk, and a load after a store, catch a bit that is not sticky or a store that fails to set the accessed bit: each would show up as an extra request. A full queue, followed by a retry, exposes a design that sets the bit on a dropped request (the retry never comes) or one that overwrites a queued entry (wrong order or lost items). A fill that collides with an access, and a page-level page, catch stale records, requests to a page being replaced, and a nonzero chunk on whole-page requests.

// File: rtl/sadt_pkg.sv
package sadt_pkg;

  typedef enum logic {
    UPD_ACCESSED = 1'b0,
    UPD_DIRTY    = 1'b1
  } upd_kind_e;

  // Chunk number of a byte offset within a page of 2**size_code base pages.
  function automatic logic [7:0] chunk_sel(logic [31:0] off, int size_code,
                                           int base_shift, int chunk_w);
    logic [31:0] shifted;
    logic [31:0] mask;
    if (size_code >= chunk_w) begin
      shifted = off >> (base_shift + size_code - chunk_w);
      mask    = (32'd1 << chunk_w) - 32'd1;
    end else begin
      shifted = off >> base_shift;
      mask    = (32'd1 << size_code) - 32'd1;
    end
    return 8'(shifted & mask);
  endfunction

endpackage

// File: rtl/sadt_vec_bank.sv
module sadt_vec_bank #(
  parameter int ENTRIES = 8,
  parameter int VEC     = 16,
  parameter int SIZE_W  = 4,
  parameter int TAG_W   = 28,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CHUNK_W = $clog2(VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [SIZE_W-1:0]  fill_size,
  input  logic               fill_track,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic [CHUNK_W-1:0] set_chunk,
  input  logic               set_dirty,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [SIZE_W-1:0]  rd_size,
  output logic               rd_track,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [VEC-1:0]     rd_avec,
  output logic [VEC-1:0]     rd_dvec,
  output logic               rd_pa,
  output logic               rd_pd
);

  logic              valid_q [ENTRIES];
  logic [SIZE_W-1:0] size_q  [ENTRIES];
  logic              track_q [ENTRIES];
  logic [TAG_W-1:0]  tag_q   [ENTRIES];
  logic [VEC-1:0]    av_q    [ENTRIES];
  logic [VEC-1:0]    dv_q    [ENTRIES];
  logic              pa_q    [ENTRIES];
  logic              pd_q    [ENTRIES];

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
        size_q[e]  <= '0;
        track_q[e] <= 1'b0;
        tag_q[e]   <= '0;
        av_q[e]    <= '0;
        dv_q[e]    <= '0;
        pa_q[e]    <= 1'b0;
        pd_q[e]    <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(e)) begin
        valid_q[e] <= 1'b1;
        size_q[e]  <= fill_size;
        track_q[e] <= fill_track;
        tag_q[e]   <= fill_tag;
        av_q[e]    <= '0;
        dv_q[e]    <= '0;
        pa_q[e]    <= 1'b0;
        pd_q[e]    <= 1'b0;
      end else if (set_en && set_idx == IDX_W'(e)) begin
        if (track_q[e]) begin
          av_q[e][set_chunk] <= 1'b1;
          if (set_dirty) dv_q[e][set_chunk] <= 1'b1;
        end else begin
          pa_q[e] <= 1'b1;
          if (set_dirty) pd_q[e] <= 1'b1;
        end
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_size  = size_q[rd_idx];
  assign rd_track = track_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_avec  = av_q[rd_idx];
  assign rd_dvec  = dv_q[rd_idx];
  assign rd_pa    = pa_q[rd_idx];
  assign rd_pd    = pd_q[rd_idx];

  // R2: a fill leaves the entry with an empty record
  assert_fill_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (av_q[$past(fill_idx)] == '0 && dv_q[$past(fill_idx)] == '0
                 && !pa_q[$past(fill_idx)] && !pd_q[$past(fill_idx)]));

  // R3: a set on a tracked entry makes the chunk's accessed bit stick
  assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(fill_en && fill_idx == set_idx) && track_q[set_idx])
      |=> av_q[$past(set_idx)][$past(set_chunk)]);

endmodule

// File: rtl/sadt_req_fifo.sv
module sadt_req_fifo #(
  parameter int WIDTH = 34,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  output logic             valid,
  input  logic             ready,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign valid = (cnt_q != '0);
  assign pop   = valid && ready;
  assign dout  = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        mem_q[wr_q] <= din;
        wr_q        <= ptr_next(wr_q);
      end
      if (pop) rd_q <= ptr_next(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9: the caller never writes into a full queue
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9: occupancy stays within the depth
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R10: a stalled request holds still
  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));

endmodule

// File: rtl/subpage_ad_tracker.sv
module subpage_ad_tracker #(
  parameter int ENTRIES    = 8,
  parameter int VEC_BITS   = 16,
  parameter int MAX_SIZE   = 8,
  parameter int BASE_SHIFT = 12,
  parameter int TAG_W      = 28,
  parameter int FIFO_DEPTH = 4,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int CHUNK_W = $clog2(VEC_BITS),
  localparam int SIZE_W  = $clog2(MAX_SIZE + 1),
  localparam int OFF_W   = BASE_SHIFT + MAX_SIZE,
  localparam int REQ_W   = TAG_W + CHUNK_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [SIZE_W-1:0]  fill_size,
  input  logic               fill_track,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               acc_valid,
  input  logic [IDX_W-1:0]   acc_idx,
  input  logic               acc_write,
  input  logic [OFF_W-1:0]   acc_offset,
  output logic               upd_valid,
  input  logic               upd_ready,
  output logic [TAG_W-1:0]   upd_tag,
  output logic [CHUNK_W-1:0] upd_chunk,
  output logic               upd_dirty,
  output logic               upd_page_level
);

  import sadt_pkg::*;

  logic               rd_valid, rd_track, rd_pa, rd_pd;
  logic [SIZE_W-1:0]  rd_size;
  logic [TAG_W-1:0]   rd_tag;
  logic [VEC_BITS-1:0] rd_avec, rd_dvec;

  logic [CHUNK_W-1:0] chunk;
  logic               bit_a, bit_d;
  logic               collide, hit, need, push, drop;
  logic               fifo_full;
  upd_kind_e          kind;
  logic [REQ_W-1:0]   req_in, req_out;

  sadt_vec_bank #(
    .ENTRIES(ENTRIES), .VEC(VEC_BITS), .SIZE_W(SIZE_W), .TAG_W(TAG_W)
  ) i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (fill_valid),
    .fill_idx  (fill_idx),
    .fill_size (fill_size),
    .fill_track(fill_track),
    .fill_tag  (fill_tag),
    .set_en    (push),
    .set_idx   (acc_idx),
    .set_chunk (chunk),
    .set_dirty (acc_write),
    .rd_idx    (acc_idx),
    .rd_valid  (rd_valid),
    .rd_size   (rd_size),
    .rd_track  (rd_track),
    .rd_tag    (rd_tag),
    .rd_avec   (rd_avec),
    .rd_dvec   (rd_dvec),
    .rd_pa     (rd_pa),
    .rd_pd     (rd_pd)
  );

  assign chunk   = CHUNK_W'(chunk_sel(32'(acc_offset), int'(rd_size),
                                      BASE_SHIFT, CHUNK_W));
  assign bit_a   = rd_track ? rd_avec[chunk] : rd_pa;
  assign bit_d   = rd_track ? rd_dvec[chunk] : rd_pd;
  assign collide = fill_valid && (fill_idx == acc_idx);
  assign hit     = acc_valid && rd_valid && !collide;
  assign need    = hit && (acc_write ? !bit_d : !bit_a);
  assign push    = need && !fifo_full;
  assign drop    = need && fifo_full;
  assign kind    = acc_write ? UPD_DIRTY : UPD_ACCESSED;

  assign req_in = {rd_tag, (rd_track ? chunk : CHUNK_W'(0)), kind == UPD_DIRTY, !rd_track};

  sadt_req_fifo #(.WIDTH(REQ_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .din  (req_in),
    .full (fifo_full),
    .valid(upd_valid),
    .ready(upd_ready),
    .dout (req_out)
  );

  assign {upd_tag, upd_chunk, upd_dirty, upd_page_level} = req_out;

  // R7: whole-page requests never name a chunk
  assert_page_level_chunk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_page_level) |-> (upd_chunk == '0));

  // R8: an access colliding with a fill queues nothing
  assert_collide_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && collide) |-> !push);

  // R9: a dropped request leaves the queue untouched when nothing leaves
  assert_drop_keeps_queue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !upd_ready) |=> (upd_valid && $stable(req_out)));

endmodule

// File: tb/test_subpage_ad_tracker.sv
module test_subpage_ad_tracker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_valid = 1'b0;
  logic [2:0]  fill_idx = '0;
  logic [3:0]  fill_size = '0;
  logic        fill_track = 1'b0;
  logic [27:0] fill_tag = '0;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_idx = '0;
  logic        acc_write = 1'b0;
  logic [19:0] acc_offset = '0;
  logic        upd_valid;
  logic        upd_ready = 1'b1;
  logic [27:0] upd_tag;
  logic [3:0]  upd_chunk;
  logic        upd_dirty;
  logic        upd_page_level;

  always #10 clk = ~clk;

  subpage_ad_tracker i_subpage_ad_tracker (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_size(fill_size),
    .fill_track(fill_track), .fill_tag(fill_tag),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_write(acc_write),
    .acc_offset(acc_offset),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_tag(upd_tag),
    .upd_chunk(upd_chunk), .upd_dirty(upd_dirty), .upd_page_level(upd_page_level)
  );

  int checks = 0;
  int errors = 0;
  int occ = 0;
  bit done = 0;

  logic [33:0] exp_q[$];
  string       req_q[$];

  bit          m_valid [8];
  bit          m_track [8];
  int          m_size  [8];
  logic [27:0] m_tag   [8];
  logic [15:0] m_a     [8];
  logic [15:0] m_d     [8];
  bit          m_pa    [8];
  bit          m_pd    [8];

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard as the design hands requests over
  always @(negedge clk) begin
    if (rst_n && upd_valid && upd_ready && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected request", int'({upd_chunk, upd_dirty, upd_page_level}), 0);
      end else begin
        logic [33:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check({upd_tag, upd_chunk, upd_dirty, upd_page_level} == e, r, "request",
              int'({upd_tag, upd_chunk, upd_dirty, upd_page_level}), int'(e));
        occ--;
      end
    end
  end

  task automatic model_fill(int idx, int size, bit track, logic [27:0] tag);
    m_valid[idx] = 1'b1; m_track[idx] = track; m_size[idx] = size; m_tag[idx] = tag;
    m_a[idx] = '0; m_d[idx] = '0; m_pa[idx] = 1'b0; m_pd[idx] = 1'b0;
  endtask

  task automatic do_fill(int idx, int size, bit track, logic [27:0] tag);
    model_fill(idx, size, track, tag);
    fill_valid = 1'b1; fill_idx = 3'(idx); fill_size = 4'(size);
    fill_track = track; fill_tag = tag;
    @(posedge clk); #2;
    fill_valid = 1'b0;
  endtask

  task automatic do_acc(int idx, bit wr, logic [19:0] off, string req);
    int ch;
    bit need;
    if (m_valid[idx]) begin
      if (m_size[idx] >= 4) ch = int'(off >> (8 + m_size[idx])) & 15;
      else ch = int'(off >> 12) % (1 << m_size[idx]);
      if (m_track[idx]) need = wr ? !m_d[idx][ch] : !m_a[idx][ch];
      else              need = wr ? !m_pd[idx] : !m_pa[idx];
      if (need && occ < 4) begin
        exp_q.push_back({m_tag[idx], (m_track[idx] ? 4'(ch) : 4'd0), wr, !m_track[idx]});
        req_q.push_back(req);
        occ++;
        if (m_track[idx]) begin
          m_a[idx][ch] = 1'b1;
          if (wr) m_d[idx][ch] = 1'b1;
        end else begin
          m_pa[idx] = 1'b1;
          if (wr) m_pd[idx] = 1'b1;
        end
      end
    end
    acc_valid = 1'b1; acc_idx = 3'(idx); acc_write = wr; acc_offset = off;
    @(posedge clk); #2;
    acc_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic drain(string req);
    idle(8);
    check(exp_q.size() == 0, req, "requests missing", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_valid[i] = 0; m_track[i] = 0; m_size[i] = 0; m_tag[i] = '0;
      m_a[i] = '0; m_d[i] = '0; m_pa[i] = 0; m_pd[i] = 0;
    end
    idle(3);
    rst_n = 1'b1;
    idle(1);
    @(negedge clk);
    check(upd_valid == 1'b0, "R1", "idle after reset", int'(upd_valid), 0);
    @(posedge clk); #2;

    // R1: empty entry ignores accesses
    do_acc(0, 1'b0, 20'h30000, "R1");
    do_acc(0, 1'b1, 20'h30000, "R1");
    drain("R1");

    // R3/R5/R11: large page, chunk from bits 19:16
    do_fill(0, 8, 1'b1, 28'hAAA);
    do_acc(0, 1'b0, 20'h30000, "R5");
    @(negedge clk);
    check(upd_valid == 1'b1, "R11", "request next cycle", int'(upd_valid), 1);
    @(posedge clk); #2;
    do_acc(0, 1'b0, 20'h31234, "R3");
    // R4: store sets dirty, later touches stay quiet
    do_acc(0, 1'b1, 20'h30000, "R4");
    do_acc(0, 1'b1, 20'h3FFFF, "R4");
    do_acc(0, 1'b0, 20'h30010, "R4");
    do_acc(0, 1'b1, 20'hF0000, "R4");
    do_acc(0, 1'b0, 20'hF8000, "R4");
    drain("R3");

    // R5: size 4 uses bits 15:12, size 6 uses bits 17:14
    do_fill(1, 4, 1'b1, 28'h111);
    do_acc(1, 1'b0, 20'h0A000, "R5");
    do_fill(4, 6, 1'b1, 28'h444);
    do_acc(4, 1'b0, 20'h2C000, "R5");
    do_acc(4, 1'b0, 20'h2FFFF, "R5");
    // R6: small pages, one chunk per base page
    do_fill(2, 2, 1'b1, 28'h222);
    do_acc(2, 1'b0, 20'h03000, "R6");
    do_acc(2, 1'b1, 20'h02FFF, "R6");
    do_fill(3, 0, 1'b1, 28'h333);
    do_acc(3, 1'b1, 20'h00FFF, "R6");
    drain("R6");

    // R7: page-level bits
    do_fill(5, 8, 1'b0, 28'h555);
    do_acc(5, 1'b0, 20'h50000, "R7");
    do_acc(5, 1'b0, 20'h90000, "R7");
    do_acc(5, 1'b1, 20'h90000, "R7");
    do_acc(5, 1'b1, 20'h10000, "R7");
    drain("R7");

    // R8/R2: fill and access to the same entry in one cycle
    model_fill(0, 8, 1'b1, 28'hBBB);
    fill_valid = 1'b1; fill_idx = 3'd0; fill_size = 4'd8; fill_track = 1'b1; fill_tag = 28'hBBB;
    acc_valid = 1'b1; acc_idx = 3'd0; acc_write = 1'b1; acc_offset = 20'h30000;
    @(posedge clk); #2;
    fill_valid = 1'b0; acc_valid = 1'b0;
    drain("R8");
    do_acc(0, 1'b1, 20'h30000, "R2");
    drain("R2");

    // R10: back-to-back order
    do_acc(1, 1'b0, 20'h01000, "R10");
    do_acc(1, 1'b0, 20'h02000, "R10");
    do_acc(1, 1'b1, 20'h03000, "R10");
    drain("R10");

    // R9: full queue drops, then retry
    upd_ready = 1'b0;
    do_fill(6, 8, 1'b1, 28'h666);
    for (int c = 0; c < 5; c++) do_acc(6, 1'b0, 20'(c << 16), "R9");
    @(negedge clk);
    check(upd_valid && upd_chunk == 4'd0, "R10", "hold while stalled", int'(upd_chunk), 0);
    @(negedge clk);
    check(upd_valid && upd_chunk == 4'd0 && upd_tag == 28'h666, "R10", "hold tag", int'(upd_tag), 'h666);
    @(posedge clk); #2;
    upd_ready = 1'b1;
    drain("R9");
    do_acc(6, 1'b0, 20'h40000, "R9");
    drain("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule